// File: doc/BRIEF.md
# Miller-Rabin Primality Tester

This block decides whether an odd 32-bit number is composite or probably prime. It runs a fixed number of witness rounds. Before the first round it removes every factor of two from n−1, which leaves n−1 = 2^s·d with d odd. In each round it asks for one witness value `a` and raises it to the power d modulo n. The exponentiation unit scans the exponent from its least significant bit, one bit per cycle. The unit then squares the result modulo n until it reaches n−1 or 1, or until s−1 squarings have been done.

A round that finds the candidate composite ends the whole test at once, and no further witness is requested. If every round passes, the candidate is reported as probably prime. Candidates below 5 and even values are answered directly, without asking for any witness. The caller supplies the candidates and chooses the witnesses. Each witness should lie in the range 2 to n−2.

Top module: `mr_prime_test`

## Requirements
- R1: While reset is held, and after it is released, `done`, `is_prime` and `wit_req` are 0.
- R2: A candidate below 5 or an even candidate is answered at the clock edge that samples `start`, with no witness request. The candidate 3 gives `is_prime`=1. The values 0, 1, 2 and 4, and all even values, give `is_prime`=0.
- R3: Each round raises `wit_req` for exactly one cycle. The witness on `wit` is captured at the clock edge that ends that cycle.
- R4: The round's first value is x = a^d mod n, with n−1 = 2^s·d and d odd. Every modular product is formed at full double width before reduction, so results are exact for candidates close to 2^32.
- R5: A round passes when x is 1 or n−1. Otherwise x is squared modulo n, at most s−1 times. A square equal to n−1 passes the round. A square equal to 1, or running out of squarings, marks the candidate composite and ends the test with no further witness request.
- R6: `is_prime` is 1 only when all ROUNDS rounds pass. The candidate 2750263, tested with witnesses 2, 3, 5 and 7, gives `is_prime`=1.
- R7: `done` is a one-cycle pulse at the end of each test. `is_prime` holds its value from that pulse until the next `done`.
- R8: A `start` pulse while a test is running is ignored. The running test finishes with the result for its own candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test on `cand`; ignored while a test is running |
| cand | input | W | Candidate to test |
| wit_req | output | 1 | One-cycle request for the next witness |
| wit | input | W | Witness value, captured at the edge that ends `wit_req` |
| done | output | 1 | One-cycle pulse when the verdict is ready |
| is_prime | output | 1 | 1 = probably prime, 0 = composite; held between tests |

## Verification
The bench builds the block with W=32 and ROUNDS=4. With four rounds a strong pseudoprime can pass its early rounds and then fail a later one, and the request count shows exactly where the test stopped. The full 32-bit width allows the candidate 4294967291, whose products need the complete 64-bit intermediate. A small candidate such as 9, which has s=3, runs out of squarings. The candidate 25 with witness 7 passes its round on a square that reaches n−1.

// File: rtl/mr_pkg.sv
package mr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_REQ,
    ST_EXP,
    ST_EVAL,
    ST_SQR,
    ST_SQCHK
  } mr_state_e;
endpackage

// File: rtl/mr_modmul.sv
module mr_modmul #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic [W-1:0] r
);
  localparam int W2 = 2 * W;

  logic [W2-1:0] prod;

  // full double-width product, then reduction by the modulus
  assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign r    = W'(prod % {{W{1'b0}}, m});
endmodule

// File: rtl/mr_modexp.sv
module mr_modexp #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] base,
  input  logic [W-1:0] expo,
  input  logic [W-1:0] modn,
  output logic         done,
  output logic [W-1:0] res
);
  localparam int NMUL = 2;

  logic [W-1:0] acc_q, sq_q, e_q, m_q;
  logic         run_q;
  logic [W-1:0] mx [NMUL];
  logic [W-1:0] my [NMUL];
  logic [W-1:0] mp [NMUL];

  // multiplier 0 updates the accumulator, multiplier 1 squares the base
  always_comb begin
    mx[0] = acc_q;
    my[0] = sq_q;
    mx[1] = sq_q;
    my[1] = sq_q;
  end

  for (genvar gi = 0; gi < NMUL; gi++) begin : g_mul
    mr_modmul #(.W(W)) u_mul (
      .a(mx[gi]),
      .b(my[gi]),
      .m(m_q),
      .r(mp[gi])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      sq_q  <= '0;
      e_q   <= '0;
      m_q   <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        acc_q <= W'(1);
        sq_q  <= base;
        e_q   <= expo;
        m_q   <= modn;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (e_q == '0) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end else begin
          if (e_q[0]) acc_q <= mp[0];
          sq_q <= mp[1];
          e_q  <= e_q >> 1;
        end
      end
    end
  end

  assign res = acc_q;

  // R4: a finished power is always reduced below the modulus
  p_res_reduced_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (res < m_q));
endmodule

// File: rtl/mr_prime_test.sv
module mr_prime_test
  import mr_pkg::*;
#(
  parameter int W      = 32,
  parameter int ROUNDS = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] cand,
  output logic         wit_req,
  input  logic [W-1:0] wit,
  output logic         done,
  output logic         is_prime
);
  localparam int SW = $clog2(W) + 1;
  localparam int RW = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;

  mr_state_e    st;
  logic [W-1:0] n_q, d_q, x_q, nm1;
  logic [SW-1:0] s_q, left_q;
  logic [RW-1:0] rnd_q;
  logic         exp_go, exp_done, pass_now, fail_now;
  logic [W-1:0] exp_res, sq_res;

  assign nm1    = n_q - W'(1);
  assign exp_go = (st == ST_REQ);

  mr_modexp #(.W(W)) u_exp (
    .clk (clk),
    .rst (rst),
    .go  (exp_go),
    .base(wit),
    .expo(d_q),
    .modn(n_q),
    .done(exp_done),
    .res (exp_res)
  );

  mr_modmul #(.W(W)) u_sqr (
    .a(x_q),
    .b(x_q),
    .m(n_q),
    .r(sq_res)
  );

  always_comb begin
    pass_now = 1'b0;
    fail_now = 1'b0;
    if (st == ST_EVAL) begin
      if (x_q == W'(1) || x_q == nm1) pass_now = 1'b1;
      else if (s_q == SW'(1))         fail_now = 1'b1;
    end else if (st == ST_SQCHK) begin
      if (x_q == nm1)                               pass_now = 1'b1;
      else if (x_q == W'(1) || left_q == '0)        fail_now = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      done     <= 1'b0;
      is_prime <= 1'b0;
      wit_req  <= 1'b0;
      n_q      <= '0;
      d_q      <= '0;
      x_q      <= '0;
      s_q      <= '0;
      left_q   <= '0;
      rnd_q    <= '0;
    end else begin
      done    <= 1'b0;
      wit_req <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          if (cand < W'(5) || !cand[0]) begin
            done     <= 1'b1;
            is_prime <= (cand == W'(3));
          end else begin
            n_q <= cand;
            d_q <= cand - W'(1);
            s_q <= '0;
            st  <= ST_SPLIT;
          end
        end
        ST_SPLIT: begin
          if (!d_q[0]) begin
            d_q <= d_q >> 1;
            s_q <= s_q + SW'(1);
          end else begin
            rnd_q   <= '0;
            wit_req <= 1'b1;
            st      <= ST_REQ;
          end
        end
        ST_REQ: st <= ST_EXP;
        ST_EXP: if (exp_done) begin
          x_q <= exp_res;
          st  <= ST_EVAL;
        end
        ST_SQR: begin
          x_q    <= sq_res;
          left_q <= left_q - SW'(1);
          st     <= ST_SQCHK;
        end
        ST_EVAL, ST_SQCHK: begin
          if (pass_now) begin
            if (rnd_q == RW'(ROUNDS - 1)) begin
              done     <= 1'b1;
              is_prime <= 1'b1;
              st       <= ST_IDLE;
            end else begin
              rnd_q   <= rnd_q + RW'(1);
              wit_req <= 1'b1;
              st      <= ST_REQ;
            end
          end else if (fail_now) begin
            done     <= 1'b1;
            is_prime <= 1'b0;
            st       <= ST_IDLE;
          end else begin
            if (st == ST_EVAL) left_q <= s_q - SW'(1);
            st <= ST_SQR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: a witness request lasts exactly one cycle
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    wit_req |=> !wit_req);

  // R2: an idle block never asks for a witness
  p_idle_no_req_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !wit_req);

  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: the verdict only moves together with done
  p_verdict_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(is_prime));

  // R8: the candidate under test is not replaced mid-test
  p_cand_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(n_q));
endmodule

// File: tb/mr_prime_test_tb.sv
module mr_prime_test_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int ROUNDS = 4;

  typedef struct packed {
    logic [31:0] n;
    logic [31:0] w0;
    logic [31:0] w1;
    logic [31:0] w2;
    logic [31:0] w3;
    logic        pr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{32'd2750263,    32'd2, 32'd3, 32'd5, 32'd7, 1'b1},
    '{32'd2047,       32'd2, 32'd3, 32'd5, 32'd7, 1'b0},
    '{32'd2047,       32'd3, 32'd2, 32'd5, 32'd7, 1'b0},
    '{32'd561,        32'd2, 32'd3, 32'd5, 32'd7, 1'b0},
    '{32'd7919,       32'd2, 32'd3, 32'd5, 32'd7, 1'b1},
    '{32'd5,          32'd2, 32'd3, 32'd2, 32'd3, 1'b1},
    '{32'd9,          32'd2, 32'd4, 32'd5, 32'd7, 1'b0},
    '{32'd25,         32'd7, 32'd2, 32'd3, 32'd4, 1'b0},
    '{32'd4294967291, 32'd2, 32'd3, 32'd5, 32'd7, 1'b1},
    '{32'd65537,      32'd3, 32'd5, 32'd7, 32'd11, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] cand = '0;
  logic [W-1:0] wit = '0;
  logic wit_req, done, is_prime;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mr_prime_test #(.W(W), .ROUNDS(ROUNDS)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cand(cand),
    .wit_req(wit_req), .wit(wit), .done(done), .is_prime(is_prime)
  );

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint unsigned powmod(longint unsigned b, longint unsigned e,
                                             longint unsigned m);
    longint unsigned r = 1;
    b = b % m;
    while (e != 0) begin
      if (e[0]) r = (r * b) % m;
      b = (b * b) % m;
      e = e >> 1;
    end
    return r;
  endfunction

  // reference verdict and number of witnesses consumed
  function automatic int model(longint unsigned n, logic [31:0] ws [4], output bit pr);
    longint unsigned d = n - 1;
    longint unsigned x;
    int s = 0;
    int reqs = 0;
    bit pass;
    while (!d[0]) begin
      d = d >> 1;
      s++;
    end
    pr = 1'b0;
    for (int r = 0; r < ROUNDS; r++) begin
      x = powmod(longint'(ws[r]), d, n);
      reqs++;
      if (x == 1 || x == n - 1) continue;
      pass = 1'b0;
      for (int j = 1; j < s; j++) begin
        x = (x * x) % n;
        if (x == n - 1) begin pass = 1'b1; break; end
        if (x == 1) break;
      end
      if (!pass) return reqs;
    end
    pr = 1'b1;
    return reqs;
  endfunction

  task automatic run_test(input logic [31:0] n, input logic [31:0] ws [4], input bit poke,
                          output bit pr, output int reqs, output int cyc,
                          output bit ok, output bit b2b);
    bit prev = 1'b0;
    @(negedge clk);
    start = 1'b1;
    cand  = n;
    reqs  = 0;
    cyc   = 0;
    ok    = 1'b0;
    b2b   = 1'b0;
    pr    = 1'b0;
    forever begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (poke && cyc == 6) begin
        start = 1'b1;
        cand  = 32'd9;
      end
      if (wit_req) begin
        if (prev) b2b = 1'b1;
        if (reqs < 4) wit = ws[reqs];
        reqs++;
      end
      prev = wit_req;
      if (done) begin
        pr = is_prime;
        ok = 1'b1;
        break;
      end
      if (cyc > 5000) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit pr, ok, b2b, mpr, hold;
    int reqs, cyc, mreqs;
    logic [31:0] ws [4];

    repeat (3) @(negedge clk);
    // R1: outputs idle under reset
    chk(!done && !is_prime && !wit_req, "R1 reset", {done, is_prime, wit_req}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !is_prime && !wit_req, "R1 after reset", {done, is_prime, wit_req}, 0);

    // table walk: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      ws = '{VECS[i].w0, VECS[i].w1, VECS[i].w2, VECS[i].w3};
      mreqs = model(longint'(VECS[i].n), ws, mpr);
      run_test(VECS[i].n, ws, 1'b0, pr, reqs, cyc, ok, b2b);
      chk(ok, "R6 done seen", ok, 1);
      chk(pr == VECS[i].pr, "R6 verdict", pr, VECS[i].pr);
      chk(pr == mpr, "R4 verdict vs model", pr, mpr);
      chk(reqs == mreqs, "R5 witness count", reqs, mreqs);
      chk(!b2b, "R3 single-cycle request", b2b, 0);
      // R7: done drops, verdict holds
      hold = is_prime;
      @(negedge clk);
      chk(!done, "R7 done pulse", done, 0);
      chk(is_prime == hold, "R7 verdict held", is_prime, hold);
    end

    // R2: small and even candidates
    ws = '{32'd2, 32'd2, 32'd2, 32'd2};
    run_test(32'd3, ws, 1'b0, pr, reqs, cyc, ok, b2b);
    chk(ok && pr, "R2 three is prime", pr, 1);
    chk(reqs == 0 && cyc == 1, "R2 three immediate", cyc * 100 + reqs, 100);
    run_test(32'd1, ws, 1'b0, pr, reqs, cyc, ok, b2b);
    chk(ok && !pr && reqs == 0 && cyc == 1, "R2 one composite", pr, 0);
    run_test(32'd2, ws, 1'b0, pr, reqs, cyc, ok, b2b);
    chk(ok && !pr && reqs == 0 && cyc == 1, "R2 two composite", pr, 0);
    run_test(32'd1000, ws, 1'b0, pr, reqs, cyc, ok, b2b);
    chk(ok && !pr && reqs == 0 && cyc == 1, "R2 even composite", pr, 0);

    // R8: start during a test is ignored
    ws = '{32'd2, 32'd3, 32'd5, 32'd7};
    run_test(32'd2750263, ws, 1'b1, pr, reqs, cyc, ok, b2b);
    chk(ok && pr, "R8 busy start ignored", pr, 1);
    chk(reqs == 4, "R8 full round count", reqs, 4);
    @(negedge clk);
    chk(!done && !wit_req, "R8 no second test", {done, wit_req}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule